// File: doc/BRIEF.md
# Burst Bus Master

This block drives the master side of a synchronous, byte-addressable external bus on behalf of one internal requester. The requester hands over one request at a time: read or write, single or burst, a 32-bit start address and the width of the slave port (32, 16 or 8 bits). The master latches the request and waits until the bus grant input is high. It then drives a one-cycle start strobe and presents the external address, direction, burst flag and size code in that same cycle. It keeps them unchanged until the slave has acknowledged the last beat.

A burst begins at the requested unit and stops at the end of the aligned 32-byte line. Bursts never wrap, so the beat count follows from the start offset and the port width. Each acknowledged beat either returns read data to the requester or consumes the write word the requester presents. The master also reports the byte address of the beat in progress. Output enables tell the pad ring when the strobe, attributes and write data are driven. When they are released, external pull-ups take the lines to their inactive level.

Top module: `xbus_master`

## Requirements
- R1: The start strobe `ts_out` rises only in the cycle after `bus_grant` was sampled high with a request pending. It is high for exactly one cycle per transaction and stays low until that transaction's final beat is acknowledged.
- R2: `addr_out`, `rdwr_out`, `burst_out` and `tsize_out` take their values in the strobe cycle. They hold steady in every later cycle until the final acknowledge.
- R3: `rdwr_out` is 1 for a read and 0 for a write.
- R4: `burst_out` is 1 for a burst request and 0 for a single transfer.
- R5: `req_port` codes the port width as 0 = 32-bit, 1 = 16-bit and 2 = 8-bit. `tsize_out` is 2'b00 for a 32-bit port, 2'b10 for a 16-bit port and 2'b01 for an 8-bit port.
- R6: A single transfer has one beat. A burst has (32 − offset)/W beats, where W is the port width in bytes and offset is the start address modulo 32. That gives at most 8, 16 or 32 beats. `beat_last` is high with the acknowledge of the final beat only.
- R7: `beat_addr` equals the start address during the first beat and grows by W after each acknowledged beat.
- R8: `addr_out` carries bits 23:0 of the start address.
- R9: `ctl_oe` is high from the strobe cycle through the final acknowledge cycle and low otherwise. `data_oe` is high only within that window and only for writes.
- R10: `req_ready` is high only while idle. A new request takes effect only after the final acknowledge, and its strobe again waits for the grant.
- R11: On each acknowledge of a read, `rsp_valid` is high with `rsp_data` equal to `data_in`. On each acknowledge of a write, `wr_take` is high and `data_out` equals `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = burst to end of line |
| req_addr | input | 32 | Start byte address, aligned to the port width |
| req_port | input | 2 | Slave port width code |
| wr_data | input | 32 | Write word for the current beat |
| wr_take | output | 1 | Current write beat acknowledged |
| rsp_valid | output | 1 | Read beat acknowledged, data valid |
| rsp_data | output | 32 | Read data of the current beat |
| beat_last | output | 1 | Acknowledged beat is the final one |
| beat_addr | output | 32 | Byte address of the current beat |
| bus_grant | input | 1 | Bus ownership granted |
| ts_out | output | 1 | Transfer start strobe |
| addr_out | output | 24 | External address |
| rdwr_out | output | 1 | Direction, high = read |
| burst_out | output | 1 | Burst indicator |
| tsize_out | output | 2 | Transfer size code |
| ctl_oe | output | 1 | Output enable for strobe and attributes |
| data_out | output | 32 | Write data to the bus |
| data_oe | output | 1 | Output enable for write data |
| data_in | input | 32 | Read data from the bus |
| ta_in | input | 1 | Slave transfer acknowledge |

## Verification
The assertions assume three things about the environment. The slave raises `ta_in` only while the master owns a transaction, the grant stays high from the strobe until the final acknowledge, and the start address is aligned to the port width. The beat counter check also depends on the slave never acknowledging more beats than the line holds. The bench plays a slave that acknowledges exactly the number of beats it computes from the requirements. It drops the grant only while the master is idle or waiting for arbitration, and it only issues addresses aligned to the chosen port.

// File: rtl/xbm_pkg.sv
package xbm_pkg;

   typedef enum logic [1:0] {
      PORT_W32 = 2'd0,
      PORT_W16 = 2'd1,
      PORT_W8  = 2'd2
   } port_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ARB,
      ST_ADDR,
      ST_DATA
   } state_e;

   // log2 of the port width in bytes; unknown codes fall back to byte width
   function automatic logic [1:0] port_lg(input logic [1:0] code);
      case (port_e'(code))
         PORT_W32: port_lg = 2'd2;
         PORT_W16: port_lg = 2'd1;
         default:  port_lg = 2'd0;
      endcase
   endfunction

   // size code presented on the bus
   function automatic logic [1:0] port_tsize(input logic [1:0] code);
      case (port_e'(code))
         PORT_W32: port_tsize = 2'b00;
         PORT_W16: port_tsize = 2'b10;
         default:  port_tsize = 2'b01;
      endcase
   endfunction

endpackage

// File: rtl/xbm_beat_calc.sv
module xbm_beat_calc #(
   parameter int LINE_BYTES = 32,
   localparam int LOW_W = $clog2(LINE_BYTES),
   localparam int CNT_W = LOW_W + 1
) (
   input  logic [LOW_W-1:0] offset,
   input  logic [1:0]       lg,
   input  logic             burst,
   output logic [CNT_W-1:0] beats
);
   logic [LOW_W-1:0] unit_off;
   logic [CNT_W-1:0] line_units;

   always_comb begin
      unit_off   = offset >> lg;
      line_units = CNT_W'(LINE_BYTES) >> lg;
      beats      = burst ? (line_units - CNT_W'(unit_off)) : CNT_W'(1);
   end
endmodule

// File: rtl/xbm_beat_ctr.sv
module xbm_beat_ctr #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   localparam int LOW_W = $clog2(LINE_BYTES),
   localparam int CNT_W = LOW_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [1:0]        load_lg,
   input  logic              load_burst,
   input  logic              step,
   output logic [ADDR_W-1:0] beat_addr,
   output logic              last
);
   logic [CNT_W-1:0]  remaining;
   logic [CNT_W-1:0]  init_beats;
   logic [1:0]        lg_q;
   logic [ADDR_W-1:0] cur_addr;

   xbm_beat_calc #(.LINE_BYTES(LINE_BYTES)) u_calc (
      .offset (load_addr[LOW_W-1:0]),
      .lg     (load_lg),
      .burst  (load_burst),
      .beats  (init_beats)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remaining <= '0;
         lg_q      <= '0;
         cur_addr  <= '0;
      end else if (load) begin
         remaining <= init_beats;
         lg_q      <= load_lg;
         cur_addr  <= load_addr;
      end else if (step) begin
         remaining <= remaining - CNT_W'(1);
         cur_addr  <= cur_addr + (ADDR_W'(1) << lg_q);
      end
   end

   assign beat_addr = cur_addr;
   assign last      = (remaining == CNT_W'(1));

   // R6
   beat_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (remaining != '0));

   // R6
   beat_last_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last && !load) |=> (remaining == '0));
endmodule

// File: rtl/xbm_seq.sv
module xbm_seq
   import xbm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic bus_grant,
   input  logic ta_in,
   input  logic last,
   output logic load,
   output logic ready,
   output logic strobe,
   output logic active,
   output logic ack
);
   state_e state_q, state_d;

   always_comb begin
      active  = (state_q == ST_ADDR) || (state_q == ST_DATA);
      strobe  = (state_q == ST_ADDR);
      ready   = (state_q == ST_IDLE);
      ack     = active && ta_in;
      load    = ready && req_valid;
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (req_valid) state_d = ST_ARB;
         ST_ARB:  if (bus_grant) state_d = ST_ADDR;
         ST_ADDR: state_d = (ack && last) ? ST_IDLE : ST_DATA;
         ST_DATA: if (ack && last) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   // R1
   ts_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);

   // R1
   ts_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe) |-> $past(bus_grant));

   // R10
   no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !(ack && last)) |=> !ready);
endmodule

// File: rtl/xbus_master.sv
module xbus_master
   import xbm_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int EXT_ADDR_W = 24,
   parameter int DATA_W     = 32,
   parameter int LINE_BYTES = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_write,
   input  logic                  req_burst,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [1:0]            req_port,
   input  logic [DATA_W-1:0]     wr_data,
   output logic                  wr_take,
   output logic                  rsp_valid,
   output logic [DATA_W-1:0]     rsp_data,
   output logic                  beat_last,
   output logic [ADDR_W-1:0]     beat_addr,
   input  logic                  bus_grant,
   output logic                  ts_out,
   output logic [EXT_ADDR_W-1:0] addr_out,
   output logic                  rdwr_out,
   output logic                  burst_out,
   output logic [1:0]            tsize_out,
   output logic                  ctl_oe,
   output logic [DATA_W-1:0]     data_out,
   output logic                  data_oe,
   input  logic [DATA_W-1:0]     data_in,
   input  logic                  ta_in
);
   initial begin
      cfg_addr_chk: assert (EXT_ADDR_W > 0 && EXT_ADDR_W <= ADDR_W)
         else $error("external address wider than internal address");
      cfg_line_chk: assert (LINE_BYTES >= 4 && (LINE_BYTES & (LINE_BYTES - 1)) == 0)
         else $error("line size must be a power of two of at least 4");
      cfg_data_chk: assert (DATA_W >= 32)
         else $error("data path narrower than the widest port");
   end

   logic                  load, active, ack, last;
   logic                  wr_q, burst_q;
   logic [1:0]            port_q;
   logic [EXT_ADDR_W-1:0] ext_q;

   xbm_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .bus_grant (bus_grant),
      .ta_in     (ta_in),
      .last      (last),
      .load      (load),
      .ready     (req_ready),
      .strobe    (ts_out),
      .active    (active),
      .ack       (ack)
   );

   xbm_beat_ctr #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_addr  (req_addr),
      .load_lg    (port_lg(req_port)),
      .load_burst (req_burst),
      .step       (ack),
      .beat_addr  (beat_addr),
      .last       (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         burst_q <= 1'b0;
         port_q  <= '0;
         ext_q   <= '0;
      end else if (load) begin
         wr_q    <= req_write;
         burst_q <= req_burst;
         port_q  <= req_port;
         ext_q   <= req_addr[EXT_ADDR_W-1:0];
      end
   end

   assign addr_out  = ext_q;
   assign rdwr_out  = !wr_q;
   assign burst_out = burst_q;
   assign tsize_out = port_tsize(port_q);
   assign ctl_oe    = active;
   assign data_oe   = active && wr_q;
   assign data_out  = wr_data;
   assign rsp_data  = data_in;
   assign rsp_valid = ack && !wr_q;
   assign wr_take   = ack && wr_q;
   assign beat_last = ack && last;

   // R2
   attr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_oe && !ts_out) |-> $stable({addr_out, rdwr_out, burst_out, tsize_out}));

   // R9
   oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ts_out |-> ctl_oe);

   // R9
   data_oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> (ctl_oe && !rdwr_out));

   // R11
   ack_one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_valid, wr_take}));
endmodule

// File: tb/xbus_master_bench.sv
module xbus_master_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_port = '0;
   logic [31:0] wr_data = '0, data_in = '0;
   logic        bus_grant = 1'b1, ta_in = 1'b0;
   logic        req_ready, wr_take, rsp_valid, beat_last, ts_out;
   logic        rdwr_out, burst_out, ctl_oe, data_oe;
   logic [31:0] rsp_data, beat_addr, data_out;
   logic [23:0] addr_out;
   logic [1:0]  tsize_out;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   xbus_master u_xbus_master (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_burst(req_burst), .req_addr(req_addr), .req_port(req_port),
      .wr_data(wr_data), .wr_take(wr_take), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .beat_last(beat_last), .beat_addr(beat_addr),
      .bus_grant(bus_grant), .ts_out(ts_out), .addr_out(addr_out),
      .rdwr_out(rdwr_out), .burst_out(burst_out), .tsize_out(tsize_out),
      .ctl_oe(ctl_oe), .data_out(data_out), .data_oe(data_oe),
      .data_in(data_in), .ta_in(ta_in)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic t_reset;
      chk(req_ready == 1'b1, "R10", "ready after reset", 64'(req_ready), 64'd1);
      chk(ts_out == 1'b0,    "R1",  "strobe after reset", 64'(ts_out), 64'd0);
      chk(ctl_oe == 1'b0,    "R9",  "ctl_oe after reset", 64'(ctl_oe), 64'd0);
      chk(data_oe == 1'b0,   "R9",  "data_oe after reset", 64'(data_oe), 64'd0);
   endtask

   // one transaction as seen by a slave with fixed wait states per beat
   task automatic run_xfer(input bit wr, input bit bu, input logic [31:0] a,
                           input logic [1:0] p, input int waits, input int gdelay);
      int lg;
      int nb;
      logic [1:0] exp_ts;
      logic [31:0] pat;
      bit first;
      lg = (p == 2'd0) ? 2 : (p == 2'd1) ? 1 : 0;
      nb = bu ? ((32 >> lg) - ((a & 32'd31) >> lg)) : 1;
      exp_ts = (p == 2'd0) ? 2'b00 : (p == 2'd1) ? 2'b10 : 2'b01;
      @(negedge clk);
      if (gdelay > 0) bus_grant = 1'b0;
      req_valid = 1'b1; req_write = wr; req_burst = bu; req_addr = a; req_port = p;
      chk(req_ready == 1'b1, "R10", "ready idle", 64'(req_ready), 64'd1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R10", "ready busy", 64'(req_ready), 64'd0);
      for (int g = 0; g < gdelay; g++) begin
         chk(ts_out == 1'b0 && ctl_oe == 1'b0, "R1", "no strobe without grant",
             64'({ts_out, ctl_oe}), 64'd0);
         @(negedge clk);
      end
      bus_grant = 1'b1;
      chk(ts_out == 1'b0, "R1", "strobe before grant sampled", 64'(ts_out), 64'd0);
      @(negedge clk);
      chk(ts_out == 1'b1, "R1", "strobe after grant", 64'(ts_out), 64'd1);
      chk(addr_out == a[23:0], "R8", "external address", 64'(addr_out), 64'(a[23:0]));
      chk(rdwr_out == !wr, "R3", "direction", 64'(rdwr_out), 64'(!wr));
      chk(burst_out == bu, "R4", "burst flag", 64'(burst_out), 64'(bu));
      chk(tsize_out == exp_ts, "R5", "size code", 64'(tsize_out), 64'(exp_ts));
      chk(ctl_oe == 1'b1 && data_oe == wr, "R9", "enables at strobe",
          64'({ctl_oe, data_oe}), 64'({1'b1, wr}));
      first = 1;
      for (int b = 0; b < nb; b++) begin
         pat = {8'(b), 24'h5A3C00} ^ a;
         for (int w = 0; w <= waits; w++) begin
            ta_in = (w == waits);
            data_in = pat; wr_data = pat;
            #1;
            if (!first) begin
               chk(ts_out == 1'b0, "R1", "strobe single cycle", 64'(ts_out), 64'd0);
               chk(addr_out == a[23:0] && rdwr_out == !wr && burst_out == bu &&
                   tsize_out == exp_ts, "R2", "attributes held",
                   64'({addr_out, rdwr_out, burst_out, tsize_out}),
                   64'({a[23:0], !wr, bu, exp_ts}));
            end
            first = 0;
            chk(beat_addr == a + (32'(b) << lg), "R7", "beat address",
                64'(beat_addr), 64'(a + (32'(b) << lg)));
            if (w == waits) begin
               chk(beat_last == (b == nb - 1), "R6", "last flag",
                   64'(beat_last), 64'(b == nb - 1));
               if (wr) begin
                  chk(wr_take && !rsp_valid && data_out == pat && data_oe, "R11",
                      "write beat", 64'({wr_take, rsp_valid, data_out}),
                      64'({1'b1, 1'b0, pat}));
               end else begin
                  chk(rsp_valid && !wr_take && rsp_data == pat, "R11",
                      "read beat", 64'({rsp_valid, wr_take, rsp_data}),
                      64'({1'b1, 1'b0, pat}));
               end
            end else begin
               chk(!rsp_valid && !wr_take && !beat_last, "R11", "no beat in wait",
                   64'({rsp_valid, wr_take, beat_last}), 64'd0);
            end
            @(negedge clk);
            ta_in = 1'b0;
         end
      end
      #1;
      chk(ctl_oe == 1'b0 && data_oe == 1'b0, "R9", "enables released",
          64'({ctl_oe, data_oe}), 64'd0);
      chk(ts_out == 1'b0, "R1", "no strobe after end", 64'(ts_out), 64'd0);
      chk(req_ready == 1'b1, "R10", "idle after final ack", 64'(req_ready), 64'd1);
   endtask

   task automatic t_single_read;   run_xfer(0, 0, 32'h0000_1000, 2'd0, 0, 0); endtask
   task automatic t_single_write8; run_xfer(1, 0, 32'h0000_2003, 2'd2, 2, 0); endtask
   task automatic t_burst_mid32;   run_xfer(0, 1, 32'h0000_0014, 2'd0, 1, 0); endtask
   task automatic t_burst_tail16;  run_xfer(1, 1, 32'h0000_001E, 2'd1, 0, 0); endtask
   task automatic t_burst_full8;   run_xfer(0, 1, 32'h0000_0040, 2'd2, 0, 0); endtask
   task automatic t_burst_gnt32;   run_xfer(1, 1, 32'h0000_0100, 2'd0, 0, 4); endtask
   task automatic t_truncate;      run_xfer(0, 0, 32'hAB12_3450, 2'd1, 1, 0); endtask
   task automatic t_back_to_back;
      run_xfer(0, 1, 32'h0000_0208, 2'd1, 0, 0);
      run_xfer(1, 0, 32'h0000_0300, 2'd0, 0, 3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_read();
      t_single_write8();
      t_burst_mid32();
      t_burst_tail16();
      t_burst_full8();
      t_burst_gnt32();
      t_truncate();
      t_back_to_back();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule